// File: doc/BRIEF.md
# Out-of-band thermal and clock responder

This block serves out-of-band read requests that a peripheral sends across a shared serial link to the host side. It holds a one-byte temperature value and a coherent snapshot of the real-time clock: seven time and date bytes plus a flag byte that describes how those bytes are encoded. Both are reloaded from local sources on periodic ticks. The temperature source ticks about once per millisecond.

A request carries a destination address. The block recognises two fixed addresses, one for temperature and one for time. For either of these it sends a posted response packet, one byte per handshake, on a valid/ready stream. Every packet starts with the destination address and a payload byte count, and the payload follows. A request for any other address produces no packet and increments a saturating drop counter. The snapshot is loaded in one cycle, and no load takes place while a packet is on the stream. A response therefore never mixes bytes from two captures, and a carry between the seconds and the year cannot appear inside a packet.

Top module: `oob_thermal_rtc_responder`

## Requirements
- R1: After reset, tx_valid is 0, req_ready is 1, drop_count is 0, and the stored temperature, time bytes and flags are all 0.
- R2: While no packet is in flight, a pulse on temp_tick loads temp_in into storage at that clock edge.
- R3: While no packet is in flight, a pulse on rtc_tick loads all seven bytes of rtc_in and the three flag inputs together at one clock edge.
- R4: A tick that arrives while a packet is in flight is held pending. It loads the live source value on the first idle cycle, so every packet carries values from a single capture.
- R5: req_ready is 1 exactly when no packet is in flight. A request is taken only on a cycle with req_valid and req_ready both 1, and a packet for a known address starts on the next cycle.
- R6: A request to TEMP_ADDR produces 3 bytes: TEMP_ADDR, then 1, then the stored temperature.
- R7: A request to RTC_ADDR produces 10 bytes: RTC_ADDR, then 8, then the flag byte, then seconds, minutes, hours, day of week, day of month, month and year. Seconds are taken from rtc_in[7:0] and year from rtc_in[55:48], with each byte at 8 bits above the one before it.
- R8: The flag byte holds daylight-saving-applied in bit 2, 24-hour format in bit 1 (0 = 12-hour, in which case hours bit 7 is 0 for AM and 1 for PM) and binary data mode in bit 0 (0 = BCD). Bits 7..3 are 0. The time bytes are sent unchanged.
- R9: A request to any other address sends no packet and adds 1 to drop_count. The count stops at its maximum value.
- R10: While tx_valid is 1 and tx_ready is 0, tx_valid and tx_data stay unchanged. tx_last is 1 only on the final byte of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_tick | input | 1 | Periodic temperature refresh strobe |
| temp_in | input | 8 | Live temperature byte |
| rtc_tick | input | 1 | Periodic time/date refresh strobe |
| rtc_in | input | 56 | Live time bytes, seconds in [7:0] up to year in [55:48] |
| rtc_dst | input | 1 | Daylight saving already applied |
| rtc_h24 | input | 1 | Hours byte in 24-hour format |
| rtc_bin | input | 1 | Time bytes binary (0 = BCD) |
| req_valid | input | 1 | Request present |
| req_addr | input | 8 | Request destination address |
| req_ready | output | 1 | Block can take a request |
| tx_valid | output | 1 | Response byte valid |
| tx_data | output | 8 | Response byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Downstream accepts the byte |
| drop_count | output | 8 | Saturating count of dropped requests |

## Verification
On every cycle the assertions check that storage does not change while a packet is in flight, that an accepted known request starts a packet on the next cycle, that stalled bytes stay fixed, that tx_last appears only with valid data, and that each dropped request moves the counter by one until it saturates. Only the bench scenarios can show the order of the payload bytes and their values, the layout of the flag byte, and which live value a deferred tick finally loads. They also show the saturation point of the counter. The bench checks these against a queue-based model on every clock.

// File: rtl/oob_resp_pkg.sv
package oob_resp_pkg;

  localparam int RTC_BYTES = 7;
  localparam int RTC_W     = RTC_BYTES * 8;
  localparam int IDX_W     = 4;

  typedef enum logic [0:0] {KIND_TEMP = 1'b0, KIND_RTC = 1'b1} pkt_kind_e;

  // Flag byte: bit2 daylight saving applied, bit1 24-hour, bit0 binary
  function automatic logic [7:0] flag_byte(input logic dst, input logic h24, input logic bin);
    return {5'b00000, dst, h24, bin};
  endfunction

  function automatic logic [IDX_W-1:0] payload_len(input pkt_kind_e kind);
    return (kind == KIND_RTC) ? IDX_W'(RTC_BYTES + 1) : IDX_W'(1);
  endfunction

  // Byte idx of a packet: 0 address, 1 count, then payload
  function automatic logic [7:0] pick_byte(input pkt_kind_e kind,
                                           input logic [IDX_W-1:0] idx,
                                           input logic [7:0] hdr_addr,
                                           input logic [7:0] temp,
                                           input logic [7:0] flags,
                                           input logic [RTC_W-1:0] rtc);
    logic [IDX_W-1:0] j;
    j = idx - IDX_W'(3);
    if (idx == '0)                  return hdr_addr;
    else if (idx == IDX_W'(1))      return {{(8-IDX_W){1'b0}}, payload_len(kind)};
    else if (kind == KIND_TEMP)     return temp;
    else if (idx == IDX_W'(2))      return flags;
    else if (j < IDX_W'(RTC_BYTES)) return rtc[j*8 +: 8];
    else                            return 8'h00;
  endfunction

endpackage

// File: rtl/oob_snapshot.sv
module oob_snapshot
  import oob_resp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             temp_tick,
  input  logic [7:0]       temp_in,
  input  logic             rtc_tick,
  input  logic [RTC_W-1:0] rtc_in,
  input  logic             rtc_dst,
  input  logic             rtc_h24,
  input  logic             rtc_bin,
  output logic [7:0]       temp_q,
  output logic [RTC_W-1:0] rtc_q,
  output logic [7:0]       flags_q
);
  logic temp_pend, rtc_pend;
  logic temp_load, rtc_load;

  assign temp_load = !busy && (temp_tick || temp_pend);
  assign rtc_load  = !busy && (rtc_tick  || rtc_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q    <= '0;
      rtc_q     <= '0;
      flags_q   <= '0;
      temp_pend <= 1'b0;
      rtc_pend  <= 1'b0;
    end else begin
      if (temp_load) begin
        temp_q    <= temp_in;
        temp_pend <= 1'b0;
      end else if (busy && temp_tick) begin
        temp_pend <= 1'b1;
      end
      if (rtc_load) begin
        rtc_q    <= rtc_in;
        flags_q  <= flag_byte(rtc_dst, rtc_h24, rtc_bin);
        rtc_pend <= 1'b0;
      end else if (busy && rtc_tick) begin
        rtc_pend <= 1'b1;
      end
    end
  end

  assert_hold_rtc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rtc_q) && $stable(flags_q)));
  assert_hold_temp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(temp_q));
  assert_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rtc_tick) |=> rtc_pend);
  assert_flag_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[7:3] == 5'b00000);

endmodule

// File: rtl/oob_req_decode.sv
module oob_req_decode
  import oob_resp_pkg::*;
#(
  parameter logic [7:0] TEMP_ADDR = 8'h10,
  parameter logic [7:0] RTC_ADDR  = 8'h20,
  parameter int         DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              req_valid,
  input  logic [7:0]        req_addr,
  output logic              req_ready,
  output logic              start,
  output pkt_kind_e         start_kind,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic req_fire, hit_temp, hit_rtc, bad_fire;

  assign req_ready  = !busy;
  assign req_fire   = req_valid && req_ready;
  assign hit_temp   = (req_addr == TEMP_ADDR);
  assign hit_rtc    = (req_addr == RTC_ADDR);
  assign start      = req_fire && (hit_temp || hit_rtc);
  assign start_kind = hit_rtc ? KIND_RTC : KIND_TEMP;
  assign bad_fire   = req_fire && !hit_temp && !hit_rtc;

  always_ff @(posedge clk) begin
    if (!rst_n)                              drop_count <= '0;
    else if (bad_fire && drop_count != DROP_MAX) drop_count <= drop_count + 1'b1;
  end

  assert_drop_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_fire && drop_count != DROP_MAX) |=> drop_count == $past(drop_count) + 1'b1);
  assert_drop_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == DROP_MAX) |=> drop_count == DROP_MAX);
  assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/oob_tx_seq.sv
module oob_tx_seq
  import oob_resp_pkg::*;
#(
  parameter logic [7:0] TEMP_ADDR = 8'h10,
  parameter logic [7:0] RTC_ADDR  = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  pkt_kind_e        start_kind,
  input  logic [7:0]       temp_q,
  input  logic [7:0]       flags_q,
  input  logic [RTC_W-1:0] rtc_q,
  input  logic             tx_ready,
  output logic             busy,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last
);
  pkt_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [7:0]       hdr_addr;
  logic             beat;

  assign hdr_addr = (kind == KIND_RTC) ? RTC_ADDR : TEMP_ADDR;
  assign tx_valid = busy;
  assign tx_last  = busy && (idx == payload_len(kind) + IDX_W'(1));
  assign tx_data  = busy ? pick_byte(kind, idx, hdr_addr, temp_q, flags_q, rtc_q) : 8'h00;
  assign beat     = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      kind <= KIND_TEMP;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        kind <= start_kind;
        idx  <= '0;
      end
    end else if (beat) begin
      if (tx_last) busy <= 1'b0;
      else         idx  <= idx + 1'b1;
    end
  end

  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (tx_valid && tx_data == hdr_addr));
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  assert_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && tx_ready) |=> !tx_valid);

endmodule

// File: rtl/oob_thermal_rtc_responder.sv
module oob_thermal_rtc_responder
  import oob_resp_pkg::*;
#(
  parameter logic [7:0] TEMP_ADDR = 8'h10,
  parameter logic [7:0] RTC_ADDR  = 8'h20,
  parameter int         DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_tick,
  input  logic [7:0]        temp_in,
  input  logic              rtc_tick,
  input  logic [55:0]       rtc_in,
  input  logic              rtc_dst,
  input  logic              rtc_h24,
  input  logic              rtc_bin,
  input  logic              req_valid,
  input  logic [7:0]        req_addr,
  output logic              req_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic [DROP_W-1:0] drop_count
);
  logic             busy, start;
  pkt_kind_e        start_kind;
  logic [7:0]       temp_q, flags_q;
  logic [RTC_W-1:0] rtc_q;

  oob_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .temp_tick(temp_tick), .temp_in(temp_in),
    .rtc_tick(rtc_tick), .rtc_in(rtc_in),
    .rtc_dst(rtc_dst), .rtc_h24(rtc_h24), .rtc_bin(rtc_bin),
    .temp_q(temp_q), .rtc_q(rtc_q), .flags_q(flags_q)
  );

  oob_req_decode #(.TEMP_ADDR(TEMP_ADDR), .RTC_ADDR(RTC_ADDR), .DROP_W(DROP_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .start(start), .start_kind(start_kind), .drop_count(drop_count)
  );

  oob_tx_seq #(.TEMP_ADDR(TEMP_ADDR), .RTC_ADDR(RTC_ADDR)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
    .temp_q(temp_q), .flags_q(flags_q), .rtc_q(rtc_q), .tx_ready(tx_ready),
    .busy(busy), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
  );

  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != tx_valid);

endmodule

// File: tb/tb_oob_thermal_rtc_responder.sv
module tb_oob_thermal_rtc_responder;
  localparam logic [7:0] TA = 8'h10;
  localparam logic [7:0] RA = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic temp_tick = 0, rtc_tick = 0, rtc_dst = 0, rtc_h24 = 0, rtc_bin = 0;
  logic [7:0] temp_in = 0, req_addr = 0;
  logic [55:0] rtc_in = 0;
  logic req_valid = 0, tx_ready = 1;
  logic req_ready, tx_valid, tx_last;
  logic [7:0] tx_data, drop_count;

  always #4 clk = ~clk;

  oob_thermal_rtc_responder #(.TEMP_ADDR(TA), .RTC_ADDR(RA), .DROP_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .temp_tick(temp_tick), .temp_in(temp_in),
    .rtc_tick(rtc_tick), .rtc_in(rtc_in), .rtc_dst(rtc_dst), .rtc_h24(rtc_h24),
    .rtc_bin(rtc_bin), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .drop_count(drop_count)
  );

  int vectors = 0, errors = 0, cycles = 0;
  bit run_cmp = 0;

  // Reference model
  byte unsigned q[$];
  byte unsigned m_temp = 0, m_flags = 0;
  byte unsigned m_rtc[7];
  bit m_tp = 0, m_rp = 0;
  int m_drop = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); m_temp = 0; m_flags = 0; m_tp = 0; m_rp = 0; m_drop = 0;
      foreach (m_rtc[i]) m_rtc[i] = 0;
    end else begin
      bit was_busy;
      was_busy = (q.size() != 0);
      if (was_busy && tx_ready) void'(q.pop_front());
      if (!was_busy) begin
        if (temp_tick || m_tp) begin m_temp = temp_in; m_tp = 0; end
        if (rtc_tick || m_rp) begin
          for (int i = 0; i < 7; i++) m_rtc[i] = rtc_in[8*i +: 8];
          m_flags = byte'(rtc_dst) * 4 + byte'(rtc_h24) * 2 + byte'(rtc_bin);
          m_rp = 0;
        end
        if (req_valid) begin
          if (req_addr == TA) begin
            q.push_back(TA); q.push_back(1); q.push_back(m_temp);
          end else if (req_addr == RA) begin
            q.push_back(RA); q.push_back(8); q.push_back(m_flags);
            for (int i = 0; i < 7; i++) q.push_back(m_rtc[i]);
          end else if (m_drop < 255) m_drop++;
        end
      end else begin
        if (temp_tick) m_tp = 1;
        if (rtc_tick) m_rp = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R5 tx_valid", int'(tx_valid), int'(q.size() != 0));
      chk("R5 req_ready", int'(req_ready), int'(q.size() == 0));
      chk("R9 drop_count", int'(drop_count), m_drop);
      if (q.size() != 0) begin
        chk("R6 R7 R8 tx_data", int'(tx_data), int'(q[0]));
        chk("R10 tx_last", int'(tx_last), int'(q.size() == 1));
      end
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      temp_tick = 0; rtc_tick = 0; req_valid = 0;
    end
  endtask

  task automatic request(input logic [7:0] a);
    @(negedge clk);
    temp_tick = 0; rtc_tick = 0;
    req_valid = 1; req_addr = a;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (tx_valid) @(negedge clk);
  endtask

  task automatic collect(output byte unsigned pk[$]);
    pk.delete();
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    forever begin
      if (tx_valid && tx_ready) begin
        pk.push_back(tx_data);
        if (tx_last) break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    byte unsigned pk[$];
    repeat (4) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 drop_count", int'(drop_count), 0);

    // R1 storage zero, R6 packet shape
    fork request(TA); collect(pk); join
    chk("R6 length", pk.size(), 3);
    chk("R1 temp zero", int'(pk[2]), 0);
    chk("R6 header", int'(pk[0]), int'(TA));

    // R2 R3 loads while idle
    @(negedge clk);
    temp_tick = 1; temp_in = 8'h3c; rtc_tick = 1;
    rtc_in = 56'h24_0c_1f_05_92_3b_17; rtc_dst = 1; rtc_h24 = 0; rtc_bin = 1;
    idle_cycles(2);
    fork request(TA); collect(pk); join
    chk("R2 temp", int'(pk[2]), 8'h3c);
    fork request(RA); collect(pk); join
    chk("R7 length", pk.size(), 10);
    chk("R7 count", int'(pk[1]), 8);
    chk("R8 flags", int'(pk[2]), 8'h05);
    chk("R3 seconds", int'(pk[3]), 8'h17);
    chk("R8 hours PM bit", int'(pk[5]), 8'h92);
    chk("R3 year", int'(pk[9]), 8'h24);

    // R4 tick during packet with backpressure (R10)
    @(negedge clk);
    req_valid = 1; req_addr = RA; tx_ready = 0;
    @(negedge clk);
    req_valid = 0; rtc_tick = 1; rtc_in = 56'h25_01_01_01_00_00_00;
    rtc_dst = 0; rtc_h24 = 1; rtc_bin = 0;
    @(negedge clk);
    rtc_tick = 0; rtc_in = 56'h26_02_02_02_01_01_01;
    idle_cycles(3);
    tx_ready = 1;
    drain();
    idle_cycles(2);
    fork request(RA); collect(pk); join
    chk("R4 deferred live year", int'(pk[9]), 8'h26);
    chk("R4 deferred flags", int'(pk[2]), 8'h02);

    // R9 drops up to saturation
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      req_valid = 1; req_addr = 8'h33;
    end
    idle_cycles(2);
    chk("R9 saturated", int'(drop_count), 255);

    // Random mix, all checked by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      temp_tick = ($urandom_range(0, 15) == 0);
      rtc_tick  = ($urandom_range(0, 15) == 0);
      temp_in   = 8'($urandom());
      rtc_in[31:0]  = $urandom();
      rtc_in[55:32] = 24'($urandom());
      {rtc_dst, rtc_h24, rtc_bin} = 3'($urandom());
      req_valid = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 2))
        0: req_addr = TA;
        1: req_addr = RA;
        default: req_addr = 8'($urandom());
      endcase
      tx_ready = ($urandom_range(0, 3) != 0);
    end
    idle_cycles(1);
    tx_ready = 1;
    drain();
    idle_cycles(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule